// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the entry into an exception or interrupt handler for a small 32-bit core. When it accepts an event (a break trap, a non-maskable interrupt, a bus fault or an external interrupt), it latches the event, its vector sources, the current program counter, the pending delay-slot count and the current values of the special registers. Over the following cycles it works out their new values. These are the condition-code register, the exception and NMI return addresses, the exception-syndrome register, the user stack pointer and the stack pointer.

It then reads the handler address from a vector table in memory through a single-word request/ready read port. After that it presents the new program counter together with all updated register values for exactly one cycle. The surrounding core writes those values into its register file on that cycle.

A version input selects between the current entry path and a legacy one. The legacy path sets a fault-enable flag instead of shifting the condition codes, and it reports an interrupt lock. It cannot take a bus fault: such an event is reported as fatal and no handler is fetched.

Top module: `exc_entry_seq`

## Requirements
- R1: On the current path (version input 32 or above), the new condition-code word keeps old bits 31:30, carries old bits 19:0 into bits 29:10, and has bits 9:0 cleared. The old word used here already has the M flag cleared when the event is an NMI.
- R2: An event of kind 1 (NMI) uses vector 0, clears the M flag (bit 7 by default), saves the PC into the NMI return register and leaves the exception return register at its old value.
- R3: The event kinds 0 (break), 2 (bus fault) and 3 (external interrupt) use the trap, fault and interrupt vector inputs respectively, and save the PC into the exception return register.
- R4: On the current path, the syndrome output equals the 8-bit vector placed in bits 15:8, with every other bit zero.
- R5: On the current path, the exception return output is reduced by the latched delay-slot count, and the delay-slot output is zero.
- R6: When the U flag (bit 6 by default) of the old condition-code word is set, the user stack pointer output takes the old stack pointer and the stack pointer output takes the kernel stack pointer. Otherwise both outputs keep their old values.
- R7: The read request stays high with a stable address equal to base + vector × 4 until ready is seen. The cycle after ready, done_valid is high for exactly one cycle and new_pc carries the word that was read.
- R8: On the legacy path (version input below 32), the condition-code output is the old word with M cleared for an NMI and with the F flag (bit 10 by default) set, and no shift is applied. The syndrome output keeps its old value, no rewind is done, the delay-slot output keeps its old value, and irq_lock is high with done_valid. On the current path irq_lock is low.
- R9: A bus fault on the legacy path produces a one-cycle fatal_err pulse two cycles after acceptance. No read is issued, done_valid is not raised, and the block returns to ready.
- R10: A bus-fault event presented while a bus-fault entry is in progress raises recursive_fault for one cycle. Any other event kind presented while busy does not raise it.
- R11: evt_ready is high only while idle. Events and input changes presented while busy do not alter the entry in progress.
- R12: After reset, evt_ready is high and rd_req, done_valid, irq_lock, fatal_err and recursive_fault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event present |
| evt_kind | input | 2 | 0 break, 1 NMI, 2 bus fault, 3 external interrupt |
| trap_vec | input | 8 | Break trap vector |
| fault_vec | input | 8 | Bus fault vector |
| irq_vec | input | 8 | Vector from the interrupt controller |
| cur_pc | input | 32 | Program counter at the event |
| dslot_in | input | 2 | Pending delay-slot count |
| ccs_in | input | 32 | Current condition-code word |
| erp_in | input | 32 | Current exception return address |
| nrp_in | input | 32 | Current NMI return address |
| exs_in | input | 32 | Current syndrome register |
| usp_in | input | 32 | Current user stack pointer |
| sp_in | input | 32 | Current stack pointer |
| ksp_in | input | 32 | Saved kernel stack pointer |
| ebp_in | input | 32 | Vector table base |
| vr_in | input | 8 | Core version |
| evt_ready | output | 1 | Idle, an event can be accepted |
| rd_req | output | 1 | Vector table read request |
| rd_addr | output | 32 | Vector table read address |
| rd_ready | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| done_valid | output | 1 | Entry complete, outputs valid |
| new_pc | output | 32 | Handler address |
| ccs_out | output | 32 | New condition-code word |
| erp_out | output | 32 | New exception return address |
| nrp_out | output | 32 | New NMI return address |
| exs_out | output | 32 | New syndrome register |
| usp_out | output | 32 | New user stack pointer |
| sp_out | output | 32 | New stack pointer |
| dslot_out | output | 2 | New delay-slot count |
| irq_lock | output | 1 | Legacy entry, interrupts locked |
| fatal_err | output | 1 | Bus fault on the legacy path |
| recursive_fault | output | 1 | Bus fault raised during a bus-fault entry |

## Verification
A wrong sequencer state shows on the read port or on done_valid within one or two cycles of acceptance. Examples are a missing or early request, a moving address, or a done pulse that lasts two cycles or never comes. A wrong latched snapshot or a wrong path choice only shows on the cycle done_valid is high. There, every register output is compared with values computed independently from the latched stimulus. Inputs are changed while the block is busy, so a design that reads live inputs instead of the snapshot gives wrong values on that same done cycle.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [1:0] {
    EV_BREAK = 2'd0,
    EV_NMI   = 2'd1,
    EV_BUSF  = 2'd2,
    EV_IRQ   = 2'd3
  } ev_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SAVE  = 2'd1,
    ST_FETCH = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_entry_pkg::*;
#(
  parameter int DW        = 32,
  parameter int VW        = 8,
  parameter int DSW       = 2,
  parameter int VRW       = 8,
  parameter int LEGACY_VR = 32,
  parameter int U_BIT     = 6,
  parameter int M_BIT     = 7,
  parameter int F_BIT     = 10,
  parameter int CCS_KEEP  = 2,
  parameter int CCS_SHIFT = 10,
  parameter int EXS_POS   = 8
)(
  input  ev_kind_e         kind,
  input  logic [VW-1:0]    trap_vec,
  input  logic [VW-1:0]    fault_vec,
  input  logic [VW-1:0]    irq_vec,
  input  logic [DW-1:0]    pc,
  input  logic [DSW-1:0]   dslot,
  input  logic [DW-1:0]    ccs,
  input  logic [DW-1:0]    erp,
  input  logic [DW-1:0]    nrp,
  input  logic [DW-1:0]    exs,
  input  logic [DW-1:0]    usp,
  input  logic [DW-1:0]    sp,
  input  logic [DW-1:0]    ksp,
  input  logic [DW-1:0]    ebp,
  input  logic [VRW-1:0]   vr,
  output logic             legacy,
  output logic             fatal,
  output logic [DW-1:0]    ccs_n,
  output logic [DW-1:0]    erp_n,
  output logic [DW-1:0]    nrp_n,
  output logic [DW-1:0]    exs_n,
  output logic [DW-1:0]    usp_n,
  output logic [DW-1:0]    sp_n,
  output logic [DSW-1:0]   dslot_n,
  output logic [DW-1:0]    fetch_addr
);

  localparam logic [VRW-1:0] LEG_LIM = VRW'(LEGACY_VR);
  localparam int             MOVE_W  = DW - CCS_KEEP - CCS_SHIFT;

  logic [VW-1:0] vec;
  logic [DW-1:0] ccs_m;
  logic [DW-1:0] ccs_shifted;
  logic [DW-1:0] erp_pick;
  logic          user_mode;

  // vector choice, return-address capture and M clear per event kind
  always_comb begin
    vec      = '0;
    erp_pick = erp;
    nrp_n    = nrp;
    ccs_m    = ccs;
    unique case (kind)
      EV_BREAK: begin
        vec      = trap_vec;
        erp_pick = pc;
      end
      EV_NMI: begin
        vec          = '0;
        ccs_m[M_BIT] = 1'b0;
        nrp_n        = pc;
      end
      EV_BUSF: begin
        vec      = fault_vec;
        erp_pick = pc;
      end
      default: begin
        vec      = irq_vec;
        erp_pick = pc;
      end
    endcase
  end

  assign ccs_shifted = {ccs_m[DW-1 -: CCS_KEEP], ccs_m[MOVE_W-1:0], {CCS_SHIFT{1'b0}}};

  assign legacy    = (vr < LEG_LIM);
  assign fatal     = legacy && (kind == EV_BUSF);
  assign user_mode = ccs[U_BIT];

  // stack swap on leaving user mode
  always_comb begin
    if (user_mode) begin
      usp_n = sp;
      sp_n  = ksp;
    end else begin
      usp_n = usp;
      sp_n  = sp;
    end
  end

  // path selection
  always_comb begin
    if (legacy) begin
      ccs_n        = ccs_m;
      ccs_n[F_BIT] = 1'b1;
      exs_n        = exs;
      erp_n        = erp_pick;
      dslot_n      = dslot;
    end else begin
      ccs_n   = ccs_shifted;
      exs_n   = DW'(vec) << EXS_POS;
      erp_n   = erp_pick - DW'(dslot);
      dslot_n = '0;
    end
  end

  assign fetch_addr = ebp + (DW'(vec) << 2);

endmodule

// File: rtl/exc_entry_fsm.sv
module exc_entry_fsm
  import exc_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_valid,
  input  logic       rd_ready,
  input  logic       abort_entry,
  output seq_state_e state_q,
  output logic       accept
);

  seq_state_e state_d;

  assign accept = (state_q == ST_IDLE) && evt_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (evt_valid) state_d = ST_SAVE;
      ST_SAVE:  state_d = abort_entry ? ST_IDLE : ST_FETCH;
      ST_FETCH: if (rd_ready) state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R11: an accepted event is followed by a busy cycle
  assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);

  // R11: the save step lasts one cycle
  assert_save_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SAVE) |=> (state_q != ST_SAVE));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int DW        = 32,
  parameter int VW        = 8,
  parameter int DSW       = 2,
  parameter int VRW       = 8,
  parameter int LEGACY_VR = 32,
  parameter int U_BIT     = 6,
  parameter int M_BIT     = 7,
  parameter int F_BIT     = 10,
  parameter int CCS_KEEP  = 2,
  parameter int CCS_SHIFT = 10,
  parameter int EXS_POS   = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [1:0]       evt_kind,
  input  logic [VW-1:0]    trap_vec,
  input  logic [VW-1:0]    fault_vec,
  input  logic [VW-1:0]    irq_vec,
  input  logic [DW-1:0]    cur_pc,
  input  logic [DSW-1:0]   dslot_in,
  input  logic [DW-1:0]    ccs_in,
  input  logic [DW-1:0]    erp_in,
  input  logic [DW-1:0]    nrp_in,
  input  logic [DW-1:0]    exs_in,
  input  logic [DW-1:0]    usp_in,
  input  logic [DW-1:0]    sp_in,
  input  logic [DW-1:0]    ksp_in,
  input  logic [DW-1:0]    ebp_in,
  input  logic [VRW-1:0]   vr_in,
  output logic             evt_ready,
  output logic             rd_req,
  output logic [DW-1:0]    rd_addr,
  input  logic             rd_ready,
  input  logic [DW-1:0]    rd_data,
  output logic             done_valid,
  output logic [DW-1:0]    new_pc,
  output logic [DW-1:0]    ccs_out,
  output logic [DW-1:0]    erp_out,
  output logic [DW-1:0]    nrp_out,
  output logic [DW-1:0]    exs_out,
  output logic [DW-1:0]    usp_out,
  output logic [DW-1:0]    sp_out,
  output logic [DSW-1:0]   dslot_out,
  output logic             irq_lock,
  output logic             fatal_err,
  output logic             recursive_fault
);

  localparam int EXS_TOP = EXS_POS + VW;

  seq_state_e state_q;
  logic       accept;

  // snapshot of the event and register inputs
  ev_kind_e       s_kind;
  logic [VW-1:0]  s_tv, s_fv, s_iv;
  logic [DW-1:0]  s_pc, s_ccs, s_erp, s_nrp, s_exs, s_usp, s_sp, s_ksp, s_ebp;
  logic [DSW-1:0] s_ds;
  logic [VRW-1:0] s_vr;

  // computed values
  logic           c_legacy, c_fatal;
  logic [DW-1:0]  c_ccs, c_erp, c_nrp, c_exs, c_usp, c_sp, c_addr;
  logic [DSW-1:0] c_ds;

  // result registers
  logic           r_leg;
  logic [DW-1:0]  r_ccs, r_erp, r_nrp, r_exs, r_usp, r_sp, r_addr, r_pc;
  logic [DSW-1:0] r_ds;

  logic           fatal_q, rec_q;
  logic           save_en, pc_en, rec_d;

  exc_entry_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_valid   (evt_valid),
    .rd_ready    (rd_ready),
    .abort_entry (c_fatal),
    .state_q     (state_q),
    .accept      (accept)
  );

  exc_entry_calc #(
    .DW(DW), .VW(VW), .DSW(DSW), .VRW(VRW), .LEGACY_VR(LEGACY_VR),
    .U_BIT(U_BIT), .M_BIT(M_BIT), .F_BIT(F_BIT),
    .CCS_KEEP(CCS_KEEP), .CCS_SHIFT(CCS_SHIFT), .EXS_POS(EXS_POS)
  ) u_calc (
    .kind       (s_kind),
    .trap_vec   (s_tv),
    .fault_vec  (s_fv),
    .irq_vec    (s_iv),
    .pc         (s_pc),
    .dslot      (s_ds),
    .ccs        (s_ccs),
    .erp        (s_erp),
    .nrp        (s_nrp),
    .exs        (s_exs),
    .usp        (s_usp),
    .sp         (s_sp),
    .ksp        (s_ksp),
    .ebp        (s_ebp),
    .vr         (s_vr),
    .legacy     (c_legacy),
    .fatal      (c_fatal),
    .ccs_n      (c_ccs),
    .erp_n      (c_erp),
    .nrp_n      (c_nrp),
    .exs_n      (c_exs),
    .usp_n      (c_usp),
    .sp_n       (c_sp),
    .dslot_n    (c_ds),
    .fetch_addr (c_addr)
  );

  // enables
  assign save_en = (state_q == ST_SAVE);
  assign pc_en   = (state_q == ST_FETCH) && rd_ready;
  assign rec_d   = (state_q != ST_IDLE) && evt_valid &&
                   (evt_kind == EV_BUSF) && (s_kind == EV_BUSF);

  // snapshot register, enabled on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_kind <= EV_BREAK;
      s_tv   <= '0;
      s_fv   <= '0;
      s_iv   <= '0;
      s_pc   <= '0;
      s_ds   <= '0;
      s_ccs  <= '0;
      s_erp  <= '0;
      s_nrp  <= '0;
      s_exs  <= '0;
      s_usp  <= '0;
      s_sp   <= '0;
      s_ksp  <= '0;
      s_ebp  <= '0;
      s_vr   <= '0;
    end else if (accept) begin
      s_kind <= ev_kind_e'(evt_kind);
      s_tv   <= trap_vec;
      s_fv   <= fault_vec;
      s_iv   <= irq_vec;
      s_pc   <= cur_pc;
      s_ds   <= dslot_in;
      s_ccs  <= ccs_in;
      s_erp  <= erp_in;
      s_nrp  <= nrp_in;
      s_exs  <= exs_in;
      s_usp  <= usp_in;
      s_sp   <= sp_in;
      s_ksp  <= ksp_in;
      s_ebp  <= ebp_in;
      s_vr   <= vr_in;
    end
  end

  // result register, enabled in the save step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_leg  <= 1'b0;
      r_ccs  <= '0;
      r_erp  <= '0;
      r_nrp  <= '0;
      r_exs  <= '0;
      r_usp  <= '0;
      r_sp   <= '0;
      r_ds   <= '0;
      r_addr <= '0;
    end else if (save_en) begin
      r_leg  <= c_legacy;
      r_ccs  <= c_ccs;
      r_erp  <= c_erp;
      r_nrp  <= c_nrp;
      r_exs  <= c_exs;
      r_usp  <= c_usp;
      r_sp   <= c_sp;
      r_ds   <= c_ds;
      r_addr <= c_addr;
    end
  end

  // handler address capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     r_pc <= '0;
    else if (pc_en) r_pc <= rd_data;
  end

  // fault pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fatal_q <= 1'b0;
      rec_q   <= 1'b0;
    end else begin
      fatal_q <= save_en && c_fatal;
      rec_q   <= rec_d;
    end
  end

  assign evt_ready       = (state_q == ST_IDLE);
  assign rd_req          = (state_q == ST_FETCH);
  assign rd_addr         = r_addr;
  assign done_valid      = (state_q == ST_DONE);
  assign irq_lock        = (state_q == ST_DONE) && r_leg;
  assign new_pc          = r_pc;
  assign ccs_out         = r_ccs;
  assign erp_out         = r_erp;
  assign nrp_out         = r_nrp;
  assign exs_out         = r_exs;
  assign usp_out         = r_usp;
  assign sp_out          = r_sp;
  assign dslot_out       = r_ds;
  assign fatal_err       = fatal_q;
  assign recursive_fault = rec_q;

  // R7: done lasts one cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  // R7: request held with a stable address until ready
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));

  // R1: low condition-code bits cleared on the current path
  assert_ccs_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !irq_lock) |-> (ccs_out[CCS_SHIFT-1:0] == '0));

  // R4: syndrome carries only the vector field on the current path
  assert_exs_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !irq_lock) |-> ((exs_out >> EXS_TOP) == '0 && exs_out[EXS_POS-1:0] == '0));

  // R5: delay slot cleared on the current path
  assert_dslot_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !irq_lock) |-> (dslot_out == '0));

  // R8: legacy entry sets F
  assert_legacy_f_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lock |-> ccs_out[F_BIT]);

  // R9: a fatal entry neither reads nor completes
  assert_fatal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |-> (!done_valid && !rd_req && evt_ready));

  // R10: recursive flag only follows a busy cycle
  assert_rec_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    recursive_fault |-> $past(!evt_ready));

endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;

  logic        clk;
  logic        rst_n;
  logic        evt_valid;
  logic [1:0]  evt_kind;
  logic [7:0]  trap_vec, fault_vec, irq_vec;
  logic [31:0] cur_pc;
  logic [1:0]  dslot_in;
  logic [31:0] ccs_in, erp_in, nrp_in, exs_in, usp_in, sp_in, ksp_in, ebp_in;
  logic [7:0]  vr_in;
  logic        evt_ready, rd_req, rd_ready, done_valid;
  logic [31:0] rd_addr, rd_data, new_pc;
  logic [31:0] ccs_out, erp_out, nrp_out, exs_out, usp_out, sp_out;
  logic [1:0]  dslot_out;
  logic        irq_lock, fatal_err, recursive_fault;

  int errors = 0;
  int checks = 0;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .trap_vec(trap_vec), .fault_vec(fault_vec), .irq_vec(irq_vec),
    .cur_pc(cur_pc), .dslot_in(dslot_in), .ccs_in(ccs_in), .erp_in(erp_in),
    .nrp_in(nrp_in), .exs_in(exs_in), .usp_in(usp_in), .sp_in(sp_in),
    .ksp_in(ksp_in), .ebp_in(ebp_in), .vr_in(vr_in),
    .evt_ready(evt_ready), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_data(rd_data), .done_valid(done_valid),
    .new_pc(new_pc), .ccs_out(ccs_out), .erp_out(erp_out), .nrp_out(nrp_out),
    .exs_out(exs_out), .usp_out(usp_out), .sp_out(sp_out),
    .dslot_out(dslot_out), .irq_lock(irq_lock), .fatal_err(fatal_err),
    .recursive_fault(recursive_fault)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_inputs(input logic [1:0] kind, input logic [7:0] vr,
                            input logic [31:0] ccs, input logic [1:0] ds);
    evt_kind  = kind;
    vr_in     = vr;
    ccs_in    = ccs;
    dslot_in  = ds;
    trap_vec  = 8'h21;
    fault_vec = 8'h3C;
    irq_vec   = 8'hA7;
    cur_pc    = 32'h0040_1238;
    erp_in    = 32'h1111_2220;
    nrp_in    = 32'h3333_4440;
    exs_in    = 32'hDEAD_BEEF;
    usp_in    = 32'h5555_0000;
    sp_in     = 32'h7FFF_F000;
    ksp_in    = 32'h8000_8000;
    ebp_in    = 32'h0010_0000;
  endtask

  // one full entry, optional injected event while busy (inj < 0: none)
  task automatic run_entry(input string name, input int wait_n,
                           input int inj, input bit exp_rec);
    logic        leg, user;
    logic [7:0]  vec;
    logic [31:0] ccs_m, e_ccs, e_erp, e_nrp, e_exs, e_usp, e_sp, e_addr, e_pc;
    logic [1:0]  e_ds;
    int          guard;
    leg  = (vr_in < 8'd32);
    user = ccs_in[6];
    case (evt_kind)
      2'd0:    vec = trap_vec;
      2'd1:    vec = 8'h00;
      2'd2:    vec = fault_vec;
      default: vec = irq_vec;
    endcase
    ccs_m = ccs_in;
    if (evt_kind == 2'd1) ccs_m[7] = 1'b0;
    e_erp = (evt_kind == 2'd1) ? erp_in : cur_pc;
    e_nrp = (evt_kind == 2'd1) ? cur_pc : nrp_in;
    if (leg) begin
      e_ccs = ccs_m | 32'h0000_0400;
      e_exs = exs_in;
      e_ds  = dslot_in;
    end else begin
      e_ccs = {ccs_m[31:30], ccs_m[19:0], 10'b0};
      e_exs = {16'b0, vec, 8'b0};
      e_erp = e_erp - {30'b0, dslot_in};
      e_ds  = 2'b00;
    end
    e_usp  = user ? sp_in  : usp_in;
    e_sp   = user ? ksp_in : sp_in;
    e_addr = ebp_in + {22'b0, vec, 2'b00};
    e_pc   = 32'h8000_0000 | (e_addr ^ 32'h0055_AA00);

    chk("R11", {name, " ready before"}, {31'b0, evt_ready}, 32'd1);
    evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
    // change live inputs: entry must use the snapshot (R11)
    cur_pc = 32'hFFFF_0000; ccs_in = 32'h0; erp_in = 32'h0; ebp_in = 32'h0;
    chk("R11", {name, " busy after accept"}, {31'b0, evt_ready}, 32'd0);
    guard = 0;
    while (!rd_req && guard < 10) begin
      @(negedge clk);
      guard++;
    end
    chk("R7", {name, " read request"}, {31'b0, rd_req}, 32'd1);
    chk("R7", {name, " read address"}, rd_addr, e_addr);
    if (inj >= 0) begin
      evt_kind  = inj[1:0];
      evt_valid = 1'b1;
      @(negedge clk);
      evt_valid = 1'b0;
      chk("R10", {name, " recursive flag"}, {31'b0, recursive_fault}, {31'b0, exp_rec});
      chk("R11", {name, " injected event ignored"}, {31'b0, evt_ready}, 32'd0);
    end
    for (int i = 0; i < wait_n; i++) begin
      @(negedge clk);
      chk("R7", {name, " request held"}, {31'b0, rd_req}, 32'd1);
      chk("R7", {name, " no early done"}, {31'b0, done_valid}, 32'd0);
    end
    rd_ready = 1'b1;
    rd_data  = e_pc;
    @(negedge clk);
    rd_ready = 1'b0;
    rd_data  = 32'h0;
    chk("R7", {name, " done"}, {31'b0, done_valid}, 32'd1);
    chk("R7", {name, " new pc"}, new_pc, e_pc);
    chk(leg ? "R8" : "R1", {name, " ccs"}, ccs_out, e_ccs);
    chk((evt_kind == 2'd1) ? "R2" : "R3", {name, " erp"}, erp_out, e_erp);
    chk("R2", {name, " nrp"}, nrp_out, e_nrp);
    chk(leg ? "R8" : "R4", {name, " exs"}, exs_out, e_exs);
    chk("R6", {name, " usp"}, usp_out, e_usp);
    chk("R6", {name, " sp"}, sp_out, e_sp);
    chk(leg ? "R8" : "R5", {name, " dslot"}, {30'b0, dslot_out}, {30'b0, e_ds});
    chk("R8", {name, " irq lock"}, {31'b0, irq_lock}, {31'b0, leg});
    @(negedge clk);
    chk("R7", {name, " done one cycle"}, {31'b0, done_valid}, 32'd0);
    chk("R11", {name, " ready after"}, {31'b0, evt_ready}, 32'd1);
  endtask

  task automatic t_reset;
    chk("R12", "ready", {31'b0, evt_ready}, 32'd1);
    chk("R12", "rd_req", {31'b0, rd_req}, 32'd0);
    chk("R12", "done", {31'b0, done_valid}, 32'd0);
    chk("R12", "lock", {31'b0, irq_lock}, 32'd0);
    chk("R12", "fatal", {31'b0, fatal_err}, 32'd0);
    chk("R12", "recursive", {31'b0, recursive_fault}, 32'd0);
  endtask

  task automatic t_break_kernel;
    set_inputs(2'd0, 8'd40, 32'hC00F_3A85, 2'd0);
    run_entry("break kernel", 0, -1, 1'b0);
  endtask

  task automatic t_nmi_user;
    set_inputs(2'd1, 8'd40, 32'h8005_A3C0, 2'd0);
    run_entry("nmi user", 2, -1, 1'b0);
  endtask

  task automatic t_nmi_dslot;
    set_inputs(2'd1, 8'd32, 32'h0000_00FF, 2'd2);
    run_entry("nmi dslot", 1, -1, 1'b0);
  endtask

  task automatic t_busf_dslot;
    set_inputs(2'd2, 8'd64, 32'h4000_0041, 2'd1);
    run_entry("busfault dslot", 3, -1, 1'b0);
  endtask

  task automatic t_irq_user_dslot;
    set_inputs(2'd3, 8'd33, 32'hFFFF_FFFF, 2'd3);
    run_entry("irq user dslot", 0, -1, 1'b0);
  endtask

  task automatic t_legacy;
    set_inputs(2'd0, 8'd10, 32'h0000_00C0, 2'd2);
    run_entry("legacy break user", 1, -1, 1'b0);
    set_inputs(2'd1, 8'd31, 32'h0008_0080, 2'd1);
    run_entry("legacy nmi", 0, -1, 1'b0);
    set_inputs(2'd3, 8'd0, 32'h0, 2'd0);
    run_entry("legacy irq", 2, -1, 1'b0);
  endtask

  task automatic t_legacy_busf;
    set_inputs(2'd2, 8'd5, 32'h0000_0040, 2'd0);
    evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
    chk("R9", "no fatal in save", {31'b0, fatal_err}, 32'd0);
    @(negedge clk);
    chk("R9", "fatal pulse", {31'b0, fatal_err}, 32'd1);
    chk("R9", "no read", {31'b0, rd_req}, 32'd0);
    chk("R9", "back to ready", {31'b0, evt_ready}, 32'd1);
    @(negedge clk);
    chk("R9", "fatal one cycle", {31'b0, fatal_err}, 32'd0);
    chk("R9", "no done", {31'b0, done_valid}, 32'd0);
  endtask

  task automatic t_recursive;
    set_inputs(2'd2, 8'd40, 32'h0000_0040, 2'd0);
    run_entry("recursive busfault", 1, 2, 1'b1);
    @(negedge clk);
    chk("R10", "flag one cycle", {31'b0, recursive_fault}, 32'd0);
  endtask

  task automatic t_busy_ignored;
    set_inputs(2'd3, 8'd40, 32'h0000_1000, 2'd0);
    run_entry("busfault during irq", 1, 2, 1'b0);
    set_inputs(2'd2, 8'd40, 32'h0000_1000, 2'd1);
    run_entry("break during busfault", 0, 0, 1'b0);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    evt_valid = 1'b0;
    rd_ready  = 1'b0;
    rd_data   = 32'h0;
    set_inputs(2'd0, 8'd40, 32'h0, 2'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_break_kernel();
    t_nmi_user();
    t_nmi_dslot();
    t_busf_dslot();
    t_irq_user_dslot();
    t_legacy();
    t_legacy_busf();
    t_recursive();
    t_busy_ignored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule